// File: doc/BRIEF.md
# Switchable Program Bank Latch with Flash Write Routing

This block is the bank register of a game cartridge that sits on an 8-bit CPU bus and decodes the 0x8000–0xFFFF window. A single written byte sets three mappings at once. The low bits pick the 16 KB program bank that appears at 0x8000–0xBFFF. Bits 6:5 pick an 8 KB character-RAM bank, limited by the fitted RAM size. Bit 7 picks which of two single-screen nametables the video side uses. The window at 0xC000–0xFFFF always shows the last program bank. The block drives the bank numbers for both windows, the character-RAM bank and the mirroring select, all from registers.

Two static options are captured while reset is held: whether the cartridge has rewritable flash, and how much character RAM is fitted. Without flash, the cartridge has plain ROM, so the CPU and the ROM both drive the data bus during a write. The latch keeps the written byte only when it matches the ROM byte at that address, and stores zero when they differ. With flash, writes to the lower half of the window are passed out as a one-cycle command strobe, carrying offset, data and current bank, to an external flash command decoder. Only writes to the upper half reach the latch, and they are stored without any masking.

Top module: `cart_bank_latch`

## Requirements
- R1: While reset is held and on the first cycle after it, the lower bank, character-RAM bank, mirroring select and command strobe are 0, and the upper bank is PRG_BANKS-1.
- R2: After an accepted latch write, the lower bank output equals the stored byte's low log2(PRG_BANKS) bits, from the clock edge that captures the write.
- R3: The upper bank output always equals PRG_BANKS-1 outside reset.
- R4: The character-RAM bank equals stored bits 6:5 ANDed with a size mask. The size code is 0 for 8 KB (mask 00), 1 for 16 KB (mask 01), and 2 or 3 for 32 KB (mask 11).
- R5: The mirroring select equals stored bit 7, where 0 means nametable A and 1 means nametable B.
- R6: With flash off, a write stores cpu_data when it equals rom_data, and stores 0 otherwise.
- R7: With flash off, a write anywhere in 0x8000–0xFFFF updates the latch. Writes below 0x8000 change no output and raise no strobe.
- R8: With flash on, a write in 0x8000–0xBFFF leaves all bank outputs unchanged. On the next edge it raises flash_cmd_stb for one cycle, with the address bits 13:0, the data, and the lower bank that was in force.
- R9: With flash on, a write in 0xC000–0xFFFF updates the latch with cpu_data, whatever rom_data is.
- R10: The flash and size options take effect only while rst is high. Changing them afterwards has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples the options |
| cfg_flash_en | input | 1 | Flash option, sampled in reset |
| cfg_chr_size | input | 2 | Character-RAM size code, sampled in reset |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| rom_data | input | 8 | ROM byte at cpu_addr, used for bus-conflict resolution |
| prg_lo_bank | output | log2(PRG_BANKS) | Bank for 0x8000–0xBFFF |
| prg_hi_bank | output | log2(PRG_BANKS) | Bank for 0xC000–0xFFFF |
| chr_bank | output | 2 | 8 KB character-RAM bank |
| mirror_sel | output | 1 | Single-screen nametable select |
| flash_cmd_stb | output | 1 | One-cycle flash command strobe |
| flash_cmd_addr | output | ADDR_W-2 | Offset within the lower window |
| flash_cmd_data | output | 8 | Command data byte |
| flash_cmd_bank | output | log2(PRG_BANKS) | Lower bank in force at the command |

## Verification
The bench builds two instances side by side on the same stimulus. One uses 32 program banks, where all five low latch bits reach the lower bank and the fixed upper bank is 31. The other uses 4 banks, which brings masking of the high latch bits and a fixed upper bank of 3 within reach. The shared vector walk re-resets with the options of each vector, so both flash settings and all four size codes are exercised. Directed sequences then cover bus-conflict mismatch, a flash write that must not disturb a bank already set, and option changes after reset.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

  // Static options captured while reset is asserted
  typedef struct packed {
    logic       flash_en;
    logic [1:0] chr_size;
  } cbl_cfg_t;

  // Destination of one CPU write cycle
  typedef enum logic [1:0] {
    RT_NONE  = 2'd0,
    RT_LATCH = 2'd1,
    RT_FLASH = 2'd2
  } cbl_route_e;

  // Size code to bank-bit mask: 0 -> 8 KB, 1 -> 16 KB, 2/3 -> 32 KB
  function automatic logic [1:0] chr_mask(input logic [1:0] size_code);
    unique case (size_code)
      2'd0:    chr_mask = 2'b00;
      2'd1:    chr_mask = 2'b01;
      default: chr_mask = 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/cbl_cfg_sample.sv
module cbl_cfg_sample
  import cbl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       flash_en_in,
  input  logic [1:0] chr_size_in,
  output cbl_cfg_t   cfg_q
);

  // Options follow the pins only while reset is held, then freeze
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.flash_en <= flash_en_in;
      cfg_q.chr_size <= chr_size_in;
    end
  end

endmodule

// File: rtl/cbl_write_route.sv
module cbl_write_route
  import cbl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  cbl_cfg_t           cfg,
  input  logic               cpu_wr,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_data,
  input  logic [DATA_W-1:0]  rom_data,
  output cbl_route_e         route,
  output logic [DATA_W-1:0]  latch_val
);

  localparam int WIN_BIT  = ADDR_W - 1;
  localparam int HALF_BIT = ADDR_W - 2;

  logic in_window;
  logic upper_half;

  assign in_window  = cpu_addr[WIN_BIT];
  assign upper_half = cpu_addr[HALF_BIT];

  always_comb begin
    route = RT_NONE;
    if (cpu_wr && in_window) begin
      if (cfg.flash_en && !upper_half) route = RT_FLASH;
      else                             route = RT_LATCH;
    end
  end

  // Plain ROM fights the CPU on the bus; a mismatch resolves to zero
  always_comb begin
    if (cfg.flash_en)              latch_val = cpu_data;
    else if (cpu_data == rom_data) latch_val = cpu_data;
    else                           latch_val = '0;
  end

endmodule

// File: rtl/cbl_map_regs.sv
module cbl_map_regs
  import cbl_pkg::*;
#(
  parameter int PRG_BANKS = 32,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  localparam int PRG_BW   = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
  localparam int OFS_W    = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  cbl_cfg_t           cfg,
  input  cbl_route_e         route,
  input  logic [DATA_W-1:0]  latch_val,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_data,
  output logic [PRG_BW-1:0]  prg_lo_bank,
  output logic [PRG_BW-1:0]  prg_hi_bank,
  output logic [1:0]         chr_bank,
  output logic               mirror_sel,
  output logic               flash_cmd_stb,
  output logic [OFS_W-1:0]   flash_cmd_addr,
  output logic [DATA_W-1:0]  flash_cmd_data,
  output logic [PRG_BW-1:0]  flash_cmd_bank
);

  localparam logic [PRG_BW-1:0] LAST_BANK = PRG_BW'(PRG_BANKS - 1);
  localparam int CHR_LO = 5;
  localparam int MIR_B  = 7;

  // Bank fields are the latch itself, registered at the write edge
  always_ff @(posedge clk) begin
    if (rst) begin
      prg_lo_bank <= '0;
      prg_hi_bank <= LAST_BANK;
      chr_bank    <= '0;
      mirror_sel  <= 1'b0;
    end else begin
      prg_hi_bank <= LAST_BANK;
      if (route == RT_LATCH) begin
        prg_lo_bank <= latch_val[PRG_BW-1:0] & LAST_BANK;
        chr_bank    <= latch_val[CHR_LO+1:CHR_LO] & chr_mask(cfg.chr_size);
        mirror_sel  <= latch_val[MIR_B];
      end
    end
  end

  // Command path toward the external flash decoder
  always_ff @(posedge clk) begin
    if (rst) begin
      flash_cmd_stb  <= 1'b0;
      flash_cmd_addr <= '0;
      flash_cmd_data <= '0;
      flash_cmd_bank <= '0;
    end else begin
      flash_cmd_stb <= (route == RT_FLASH);
      if (route == RT_FLASH) begin
        flash_cmd_addr <= cpu_addr[OFS_W-1:0];
        flash_cmd_data <= cpu_data;
        flash_cmd_bank <= prg_lo_bank;
      end
    end
  end

endmodule

// File: rtl/cart_bank_latch.sv
module cart_bank_latch
  import cbl_pkg::*;
#(
  parameter int PRG_BANKS = 32,
  parameter int ADDR_W    = 16,
  localparam int DATA_W   = 8,
  localparam int PRG_BW   = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_flash_en,
  input  logic [1:0]         cfg_chr_size,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_data,
  input  logic               cpu_wr,
  input  logic [DATA_W-1:0]  rom_data,
  output logic [PRG_BW-1:0]  prg_lo_bank,
  output logic [PRG_BW-1:0]  prg_hi_bank,
  output logic [1:0]         chr_bank,
  output logic               mirror_sel,
  output logic               flash_cmd_stb,
  output logic [ADDR_W-3:0]  flash_cmd_addr,
  output logic [DATA_W-1:0]  flash_cmd_data,
  output logic [PRG_BW-1:0]  flash_cmd_bank
);

  cbl_cfg_t          cfg_q;
  cbl_route_e        route;
  logic [DATA_W-1:0] latch_val;

  cbl_cfg_sample u_cfg (
    .clk         (clk),
    .rst         (rst),
    .flash_en_in (cfg_flash_en),
    .chr_size_in (cfg_chr_size),
    .cfg_q       (cfg_q)
  );

  cbl_write_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .cfg       (cfg_q),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_data  (cpu_data),
    .rom_data  (rom_data),
    .route     (route),
    .latch_val (latch_val)
  );

  cbl_map_regs #(.PRG_BANKS(PRG_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk            (clk),
    .rst            (rst),
    .cfg            (cfg_q),
    .route          (route),
    .latch_val      (latch_val),
    .cpu_addr       (cpu_addr),
    .cpu_data       (cpu_data),
    .prg_lo_bank    (prg_lo_bank),
    .prg_hi_bank    (prg_hi_bank),
    .chr_bank       (chr_bank),
    .mirror_sel     (mirror_sel),
    .flash_cmd_stb  (flash_cmd_stb),
    .flash_cmd_addr (flash_cmd_addr),
    .flash_cmd_data (flash_cmd_data),
    .flash_cmd_bank (flash_cmd_bank)
  );

endmodule

// File: rtl/cbl_checker.sv
module cbl_checker #(
  parameter int PRG_BANKS = 32,
  parameter int ADDR_W    = 16,
  localparam int PRG_BW   = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              flash_mode,
  input logic [1:0]        chr_size,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [7:0]        cpu_data,
  input logic              cpu_wr,
  input logic [7:0]        rom_data,
  input logic [PRG_BW-1:0] prg_lo_bank,
  input logic [PRG_BW-1:0] prg_hi_bank,
  input logic [1:0]        chr_bank,
  input logic              mirror_sel,
  input logic              flash_cmd_stb
);

  // R3
  hi_bank_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    prg_hi_bank == PRG_BW'(PRG_BANKS - 1));

  // R4
  chr_small_ram_chk: assert property (@(posedge clk) disable iff (rst)
    (chr_size == 2'd0) |-> (chr_bank == 2'b00));

  // R6
  conflict_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!flash_mode && cpu_wr && cpu_addr[ADDR_W-1] && (cpu_data != rom_data))
    |=> (prg_lo_bank == '0 && chr_bank == 2'b00 && !mirror_sel));

  // R7
  below_window_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_addr[ADDR_W-1])
    |=> (!flash_cmd_stb && $stable(prg_lo_bank) && $stable(chr_bank) && $stable(mirror_sel)));

  // R8
  flash_route_chk: assert property (@(posedge clk) disable iff (rst)
    (flash_mode && cpu_wr && cpu_addr[ADDR_W-1] && !cpu_addr[ADDR_W-2])
    |=> (flash_cmd_stb && $stable(prg_lo_bank) && $stable(chr_bank) && $stable(mirror_sel)));

  // R8
  strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    flash_cmd_stb |-> $past(cpu_wr));

endmodule

bind cart_bank_latch cbl_checker #(.PRG_BANKS(PRG_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .flash_mode    (cfg_q.flash_en),
  .chr_size      (cfg_q.chr_size),
  .cpu_addr      (cpu_addr),
  .cpu_data      (cpu_data),
  .cpu_wr        (cpu_wr),
  .rom_data      (rom_data),
  .prg_lo_bank   (prg_lo_bank),
  .prg_hi_bank   (prg_hi_bank),
  .chr_bank      (chr_bank),
  .mirror_sel    (mirror_sel),
  .flash_cmd_stb (flash_cmd_stb)
);

// File: tb/cart_bank_latch_test.sv
module cart_bank_latch_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_flash_en = 1'b0;
  logic [1:0]  cfg_chr_size = 2'd0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_wr = 1'b0;
  logic [7:0]  rom_data = 8'h00;

  logic [4:0]  lo_b, hi_b, fbank_b;
  logic [1:0]  lo_s, hi_s, fbank_s;
  logic [1:0]  chr_b, chr_s;
  logic        mir_b, mir_s, stb_b, stb_s;
  logic [13:0] faddr_b, faddr_s;
  logic [7:0]  fdata_b, fdata_s;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cart_bank_latch #(.PRG_BANKS(32)) uut (
    .clk(clk), .rst(rst), .cfg_flash_en(cfg_flash_en), .cfg_chr_size(cfg_chr_size),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr), .rom_data(rom_data),
    .prg_lo_bank(lo_b), .prg_hi_bank(hi_b), .chr_bank(chr_b), .mirror_sel(mir_b),
    .flash_cmd_stb(stb_b), .flash_cmd_addr(faddr_b), .flash_cmd_data(fdata_b),
    .flash_cmd_bank(fbank_b)
  );

  cart_bank_latch #(.PRG_BANKS(4)) uut_small (
    .clk(clk), .rst(rst), .cfg_flash_en(cfg_flash_en), .cfg_chr_size(cfg_chr_size),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr), .rom_data(rom_data),
    .prg_lo_bank(lo_s), .prg_hi_bank(hi_s), .chr_bank(chr_s), .mirror_sel(mir_s),
    .flash_cmd_stb(stb_s), .flash_cmd_addr(faddr_s), .flash_cmd_data(fdata_s),
    .flash_cmd_bank(fbank_s)
  );

  // {flash, size, addr, data, rom, exp_lo(32 banks), exp_chr, exp_mir, exp_stb}
  typedef struct packed {
    logic        flash;
    logic [1:0]  size;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  rom;
    logic [4:0]  lo;
    logic [1:0]  chr;
    logic        mir;
    logic        stb;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd0, 16'h8000, 8'h05, 8'h05, 5'h05, 2'd0, 1'b0, 1'b0},
    '{1'b0, 2'd2, 16'hC123, 8'hE7, 8'hE7, 5'h07, 2'd3, 1'b1, 1'b0},
    '{1'b0, 2'd1, 16'hFFFF, 8'h7F, 8'h7F, 5'h1F, 2'd1, 1'b0, 1'b0},
    '{1'b0, 2'd2, 16'h9000, 8'h33, 8'h32, 5'h00, 2'd0, 1'b0, 1'b0},
    '{1'b1, 2'd2, 16'hC000, 8'hAB, 8'h00, 5'h0B, 2'd1, 1'b1, 1'b0},
    '{1'b1, 2'd0, 16'h8555, 8'hAA, 8'hAA, 5'h00, 2'd0, 1'b0, 1'b1},
    '{1'b0, 2'd0, 16'h7FFF, 8'h1F, 8'h1F, 5'h00, 2'd0, 1'b0, 1'b0},
    '{1'b1, 2'd3, 16'hBFFF, 8'h60, 8'h00, 5'h00, 2'd0, 1'b0, 1'b1},
    '{1'b1, 2'd3, 16'hE000, 8'h60, 8'h00, 5'h00, 2'd3, 1'b0, 1'b0},
    '{1'b0, 2'd1, 16'hA000, 8'h40, 8'h40, 5'h00, 2'd0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic f, input logic [1:0] s);
    @(negedge clk);
    cfg_flash_en = f;
    cfg_chr_size = s;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive one write cycle; outputs are sampled on the negedge after capture
  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input logic [7:0] r);
    cpu_addr = a;
    cpu_data = d;
    rom_data = r;
    cpu_wr   = 1'b1;
    @(negedge clk);
    cpu_wr   = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state, while held and just after release
    do_reset(1'b0, 2'd2);
    chk("R1 lo", lo_b, 0);
    chk("R1 chr", chr_b, 0);
    chk("R1 mir", mir_b, 0);
    chk("R1 stb", stb_b, 0);
    chk("R1 R3 hi32", hi_b, 31);
    chk("R1 R3 hi4", hi_s, 3);

    // Vector walk: R2 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      do_reset(VECS[i].flash, VECS[i].size);
      cpu_write(VECS[i].addr, VECS[i].data, VECS[i].rom);
      chk("R2 lo32", lo_b, VECS[i].lo);
      chk("R2 lo4", lo_s, VECS[i].lo & 5'h03);
      chk("R4 chr", chr_b, VECS[i].chr);
      chk("R5 mir", mir_b, VECS[i].mir);
      chk("R8 stb", stb_b, VECS[i].stb);
      chk("R3 hi32", hi_b, 31);
      chk("R3 hi4", hi_s, 3);
      if (VECS[i].stb) begin
        chk("R8 faddr", faddr_b, VECS[i].addr[13:0]);
        chk("R8 fdata", fdata_b, VECS[i].data);
        @(negedge clk);
        chk("R8 stb one cycle", stb_b, 0);
      end
    end

    // R8: flash write after a latch write leaves the mapping and reports the bank
    do_reset(1'b1, 2'd2);
    cpu_write(16'hC000, 8'h85, 8'h00);
    chk("R9 lo", lo_b, 5);
    chk("R9 mir", mir_b, 1);
    cpu_write(16'h8000, 8'h12, 8'hFF);
    chk("R8 lo kept", lo_b, 5);
    chk("R8 mir kept", mir_b, 1);
    chk("R8 stb", stb_b, 1);
    chk("R8 fbank32", fbank_b, 5);
    chk("R8 fbank4", fbank_s, 1);
    chk("R8 fdata", fdata_b, 8'h12);

    // R7: below-window write after a set mapping changes nothing
    do_reset(1'b0, 2'd2);
    cpu_write(16'hD000, 8'hC9, 8'hC9);
    chk("R7 lo set", lo_b, 9);
    cpu_write(16'h4000, 8'h00, 8'h00);
    chk("R7 lo kept", lo_b, 9);
    chk("R7 chr kept", chr_b, 2);
    chk("R7 mir kept", mir_b, 1);
    chk("R7 stb", stb_b, 0);

    // R10: option pins changed after reset are ignored
    do_reset(1'b0, 2'd0);
    cfg_flash_en = 1'b1;
    cfg_chr_size = 2'd2;
    cpu_write(16'h9000, 8'hE7, 8'h00);
    chk("R10 conflict kept", lo_b, 0);
    chk("R10 no stb", stb_b, 0);
    cpu_write(16'h9000, 8'hE7, 8'hE7);
    chk("R10 lo", lo_b, 7);
    chk("R10 chr size kept", chr_b, 0);
    chk("R10 mir", mir_b, 1);

    finish_run();
  end

endmodule